// File: doc/BRIEF.md
# I2C Quasi-Bidirectional Port Expander Slave

This block is an I2C target that owns an eight-bit quasi-bidirectional port. Each port bit is in one of two states. In the strong-low state the pin is actively pulled to ground. In the weak-high state the pin is released and can be read as an input. There is no direction register. A host write stores one byte in the port latch. A 0 bit pulls that pin low and a 1 bit releases it. A host read returns the pin levels as they are sampled.

An active-low interrupt output tells the host that a released pin has moved away from the reference value. The reference is the value captured at the last access, so the host does not have to poll the bus. A static six-bit configuration input selects one of 64 target addresses. The general-call address and the device-identification addresses are never acknowledged.

The bus lines are synchronised into a system clock that runs much faster than SCL. All bus decoding (START, STOP, edges, shifting and ACK) is done in that clock domain.

Top module: `qio_expander`

## Requirements
- R1: After reset, pin_low is 8'h00 (every pin weak-high), int_n is 1 and sda_oe is 0.
- R2: The own address is {addr_cfg[5:0], addr_cfg[5]} (7 bits, MSB first on the bus). When the first byte after START carries that address, the slave pulls SDA low during the ninth clock. The byte's LSB selects read (1) or write (0).
- R3: The addresses 7'h00 and 7'b111110x are never acknowledged, even when addr_cfg maps to them (addr_cfg 6'h00 maps to 7'h00, and 6'h3E maps to 7'h7D).
- R4: A non-matching address gets no ACK. The bytes that follow it up to the next START are ignored and leave the port latch unchanged.
- R5: In a write, each data byte is acknowledged and stored in the latch, with pin_low = ~byte. The latch holds its value through reads and foreign transactions until the next write.
- R6: A read returns the pin levels captured at the acknowledge of the address byte. Pins that are driven low read 0. When the master ACKs a byte, the pins are captured again at the end of that ACK bit and the next byte is sent.
- R7: When the master NACKs a byte, the slave releases SDA and goes idle. A STOP in any state also returns it to idle with SDA released.
- R8: int_n goes low when any released pin (latch bit 1) differs from the reference value. The reference is all ones after reset and is recaptured at each read capture and each write. Pins driven low never raise the interrupt.
- R9: int_n returns high when the released pins match the reference again, or after an access recaptures the reference.
- R10: sda_oe only becomes asserted while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high power-on or software reset |
| addr_cfg | input | 6 | Static address selection |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| pin_i | input | 8 | Sensed port pin levels |
| pin_low | output | 8 | 1 drives the pin strongly low, 0 leaves it weak-high |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default parameters: an eight-bit port and two synchroniser stages. This makes a full sweep of all 64 address configurations practical, with one matching and one non-matching address for each. That sweep covers both reserved mappings.

With the port fixed at eight bits, the bench computes expected read bytes directly as the external level ANDed with the written latch value. It applies sixteen write patterns and a set of external patterns. It also changes the pins between the bytes of a multi-byte read and flips both released and driven pins to exercise the interrupt mask.

// File: rtl/qio_pkg.sv
package qio_pkg;

    localparam int PORT_W     = 8;
    localparam int ADDR_CFG_W = 6;
    localparam int ADDR_W     = 7;
    localparam int SYNC_N     = 2;
    localparam int BITCNT_W   = $clog2(PORT_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } slv_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    function automatic logic [ADDR_W-1:0] cfg_to_addr(input logic [ADDR_CFG_W-1:0] c);
        return {c, c[ADDR_CFG_W-1]};
    endfunction

    function automatic logic addr_reserved(input logic [ADDR_W-1:0] a);
        return (a == '0) || (a[ADDR_W-1:1] == 6'b111110);
    endfunction

endpackage

// File: rtl/qio_bus_sync.sv
module qio_bus_sync #(
    parameter int STAGES = qio_pkg::SYNC_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output qio_pkg::bus_ev_t ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_prev, sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff   <= '1;
            sda_ff   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
            scl_prev <= scl_ff[STAGES-1];
            sda_prev <= sda_ff[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_ff[STAGES-1];
        ev.sda      = sda_ff[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_prev;
        ev.scl_fall = ~ev.scl & scl_prev;
        ev.start    = ev.scl & scl_prev & sda_prev & ~ev.sda;
        ev.stop     = ev.scl & scl_prev & ~sda_prev & ev.sda;
    end
endmodule

// File: rtl/qio_slave_fsm.sv
module qio_slave_fsm
    import qio_pkg::*;
#(
    parameter int DW = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [AW-1:0] own_addr,
    input  logic [DW-1:0] rd_data,
    output logic          sda_oe,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data,
    output logic          rd_stb
);
    localparam logic [BITCNT_W-1:0] LAST_RX = BITCNT_W'(DW);
    localparam logic [BITCNT_W-1:0] LAST_TX = BITCNT_W'(DW - 1);

    slv_state_e           state;
    logic [BITCNT_W-1:0]  cnt;
    logic [DW-1:0]        sr, tx;
    logic                 rw, nack;
    logic                 hit;

    assign hit     = (sr[DW-1:1] == own_addr) && !addr_reserved(sr[DW-1:1]);
    assign wr_data = sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sr     <= '0;
            tx     <= '0;
            rw     <= 1'b0;
            nack   <= 1'b0;
            sda_oe <= 1'b0;
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (ev.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (ev.scl_rise) begin
                            sr  <= {sr[DW-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == LAST_RX) begin
                            cnt <= '0;
                            if (hit) begin
                                state  <= ST_AACK;
                                sda_oe <= 1'b1;
                                rw     <= sr[0];
                                if (sr[0]) begin
                                    tx     <= rd_data;
                                    rd_stb <= 1'b1;
                                end
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                state  <= ST_RDATA;
                                sda_oe <= ~tx[DW-1];
                            end else begin
                                state  <= ST_WDATA;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (ev.scl_rise) begin
                            sr  <= {sr[DW-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == LAST_RX) begin
                            wr_stb <= 1'b1;
                            sda_oe <= 1'b1;
                            cnt    <= '0;
                            state  <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_fall) begin
                            if (cnt == LAST_TX) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                tx     <= {tx[DW-2:0], 1'b0};
                                sda_oe <= ~tx[DW-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            nack <= ev.sda;
                        end else if (ev.scl_fall) begin
                            if (nack) begin
                                state <= ST_IDLE;
                            end else begin
                                tx     <= rd_data;
                                rd_stb <= 1'b1;
                                sda_oe <= ~rd_data[DW-1];
                                cnt    <= '0;
                                state  <= ST_RDATA;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    a_r10_oe_rises_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    a_r3_no_ack_reserved: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AACK) |-> !addr_reserved(own_addr));

    a_r7_stop_releases: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);

    a_r7_nack_releases: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RACK && nack && ev.scl_fall && !ev.start && !ev.stop) |=> (!sda_oe && state == ST_IDLE));
endmodule

// File: rtl/qio_port.sv
module qio_port #(
    parameter int DW     = qio_pkg::PORT_W,
    parameter int STAGES = qio_pkg::SYNC_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] pin_i,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_stb,
    output logic [DW-1:0] pin_s,
    output logic [DW-1:0] pin_low,
    output logic          int_n
);
    logic [STAGES-1:0][DW-1:0] pin_ff;
    logic [DW-1:0]             out_q, ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_ff <= '1;
        end else begin
            pin_ff[0] <= pin_i;
            for (int i = 1; i < STAGES; i++) pin_ff[i] <= pin_ff[i-1];
        end
    end

    assign pin_s   = pin_ff[STAGES-1];
    assign pin_low = ~out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '1;
            ref_q <= '1;
            int_n <= 1'b1;
        end else begin
            if (wr_stb) out_q <= wr_data;
            if (wr_stb || rd_stb) ref_q <= pin_s;
            int_n <= ~|((pin_s ^ ref_q) & out_q);
        end
    end

    a_r5_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(pin_low));

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_low == '0 && int_n));
endmodule

// File: rtl/qio_expander.sv
module qio_expander
    import qio_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_N
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_CFG_W-1:0] addr_cfg,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [PORT_W-1:0]     pin_i,
    output logic [PORT_W-1:0]     pin_low,
    output logic                  int_n
);
    bus_ev_t             ev;
    logic                wr_stb, rd_stb;
    logic [PORT_W-1:0]   wr_data, pin_s;

    qio_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    qio_slave_fsm #(.DW(PORT_W), .AW(ADDR_W)) u_fsm (
        .clk(clk), .rst(rst), .ev(ev),
        .own_addr(cfg_to_addr(addr_cfg)),
        .rd_data(pin_s), .sda_oe(sda_oe),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb)
    );

    qio_port #(.DW(PORT_W), .STAGES(SYNC_STAGES)) u_port (
        .clk(clk), .rst(rst), .pin_i(pin_i),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
        .pin_s(pin_s), .pin_low(pin_low), .int_n(int_n)
    );
endmodule

// File: tb/qio_expander_bench.sv
module qio_expander_bench;
    logic       clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1;
    logic [5:0] cfg = 6'd5;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic [7:0] ext = 8'hFF;
    logic       sda_oe, int_n;
    logic [7:0] pin_low;
    logic       sda_line;
    logic [7:0] pin_w;

    assign sda_line = m_sda & ~sda_oe;
    assign pin_w    = ext & ~pin_low;

    qio_expander u_qio_expander (
        .clk(clk), .rst(rst), .addr_cfg(cfg), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .pin_i(pin_w), .pin_low(pin_low), .int_n(int_n)
    );

    int  total = 0, bad = 0, r10_bad = 0;
    bit  done = 1'b0;
    logic oe_prev = 1'b0;
    localparam int HB = 12;

    always @(negedge clk) begin
        if (!rst && sda_oe && !oe_prev && m_scl) r10_bad++;
        oe_prev <= sda_oe;
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_addr(input logic [5:0] c);
        return {c, c[5]};
    endfunction

    function automatic bit exp_res(input logic [6:0] a);
        return (a == 7'h00) || (a[6:1] == 6'b111110);
    endfunction

    task automatic i_start;
        m_sda = 1'b1; waitc(HB); m_scl = 1'b1; waitc(HB);
        m_sda = 1'b0; waitc(HB); m_scl = 1'b0; waitc(2);
    endtask

    task automatic i_stop;
        m_sda = 1'b0; waitc(HB); m_scl = 1'b1; waitc(HB); m_sda = 1'b1; waitc(HB);
    endtask

    task automatic w_bit(input bit b);
        m_sda = b; waitc(HB); m_scl = 1'b1; waitc(HB); m_scl = 1'b0; waitc(2);
    endtask

    task automatic r_bit(output bit b);
        m_sda = 1'b1; waitc(HB); m_scl = 1'b1; waitc(HB/2); b = sda_line;
        waitc(HB/2); m_scl = 1'b0; waitc(2);
    endtask

    task automatic w_byte(input logic [7:0] v, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) w_bit(v[i]);
        r_bit(a);
        ack = !a;
    endtask

    task automatic r_bits(output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin r_bit(b); v[i] = b; end
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] v);
        bit ack;
        i_start; w_byte({a, 1'b0}, ack); w_byte(v, ack); i_stop; waitc(4);
    endtask

    task automatic rd_txn(input logic [6:0] a, output logic [7:0] v);
        bit ack;
        i_start; w_byte({a, 1'b1}, ack); r_bits(v); w_bit(1'b1); i_stop; waitc(4);
    endtask

    initial begin
        waitc(190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] rv, rv2, outv, e;
        logic [6:0] own;
        waitc(4);
        rst = 1'b0;
        waitc(2);
        chk(pin_low == 8'h00, "R1 pin_low", pin_low, 8'h00);
        chk(int_n == 1'b1, "R1 int_n", int_n, 1);
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);

        for (int c = 0; c < 64; c++) begin
            logic [6:0] a;
            cfg = 6'(c);
            a = exp_addr(6'(c));
            waitc(4);
            i_start; w_byte({a, 1'b0}, ack); i_stop; waitc(2);
            if (exp_res(a)) chk(ack == 1'b0, "R3 reserved", ack, 0);
            else            chk(ack == 1'b1, "R2 match", ack, 1);
            i_start; w_byte({a ^ 7'h40, 1'b0}, ack); i_stop; waitc(2);
            chk(ack == 1'b0, "R4 mismatch", ack, 0);
        end

        cfg = 6'd5;
        own = exp_addr(6'd5);
        waitc(4);
        for (int k = 0; k < 16; k++) begin
            outv = 8'(k * 29) ^ 8'h5A;
            wr_txn(own, outv);
            chk(pin_low == ~outv, "R5 write", pin_low, ~outv);
        end
        rd_txn(own, rv);
        chk(pin_low == ~outv, "R5 hold after read", pin_low, ~outv);

        i_start; w_byte({own ^ 7'h01, 1'b0}, ack); w_byte(8'h00, ack); i_stop; waitc(4);
        chk(pin_low == ~outv, "R4 ignored data", pin_low, ~outv);
        chk(ack == 1'b0, "R4 data nack", ack, 0);

        outv = 8'h0F;
        wr_txn(own, outv);
        for (int j = 0; j < 8; j++) begin
            ext = 8'(j * 37 + 3);
            waitc(8);
            rd_txn(own, rv);
            e = ext & outv;
            chk(rv == e, "R6 read", rv, e);
        end

        outv = 8'hFF;
        wr_txn(own, outv);
        ext = 8'hC3;
        waitc(8);
        i_start; w_byte({own, 1'b1}, ack);
        r_bits(rv);
        ext = 8'h3C;
        waitc(8);
        w_bit(1'b0);
        r_bits(rv2);
        w_bit(1'b1);
        waitc(8);
        chk(sda_oe == 1'b0, "R7 nack release", sda_oe, 0);
        i_stop; waitc(4);
        chk(rv == 8'hC3, "R6 first byte", rv, 8'hC3);
        chk(rv2 == 8'h3C, "R6 second byte", rv2, 8'h3C);

        ext = 8'hFF;
        waitc(8);
        rd_txn(own, rv);
        waitc(8);
        chk(int_n == 1'b1, "R8 quiet", int_n, 1);
        ext = 8'hFE; waitc(8);
        chk(int_n == 1'b0, "R8 change", int_n, 0);
        ext = 8'hFF; waitc(8);
        chk(int_n == 1'b1, "R9 return", int_n, 1);
        ext = 8'hF7; waitc(8);
        chk(int_n == 1'b0, "R8 change2", int_n, 0);
        rd_txn(own, rv); waitc(8);
        chk(int_n == 1'b1, "R9 read clears", int_n, 1);
        chk(rv == 8'hF7, "R6 int read", rv, 8'hF7);
        wr_txn(own, 8'h7F); waitc(8);
        chk(int_n == 1'b1, "R8 after write", int_n, 1);
        ext = 8'h77; waitc(8);
        chk(int_n == 1'b1, "R8 driven pin masked", int_n, 1);

        wr_txn(own, 8'h00);
        chk(pin_low == 8'hFF, "R5 all low", pin_low, 8'hFF);
        rst = 1'b1; waitc(3); rst = 1'b0; waitc(2);
        chk(pin_low == 8'h00, "R1 soft reset", pin_low, 8'h00);
        chk(int_n == 1'b1, "R1 soft reset int", int_n, 1);

        chk(r10_bad == 0, "R10 oe while scl high", r10_bad, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule